// File: doc/BRIEF.md
# GPIO Pad Community Controller

This block manages one group of general-purpose pads behind a 32-bit register port. Every pad owns a configuration record of two 32-bit words. The first word holds the value the pad drives, the live input level, an input inversion bit, a two-bit event mode and a two-bit reset-domain field. The second word is free storage that software can read and write. Pad records are laid out in an array at a fixed stride, and a read-only pointer register gives the array's byte offset.

Each pad input passes through a two-flop synchroniser and then the optional inversion. The result feeds an event detector that works in one of three modes: level, rising edge, or either edge. Detected events set sticky bits in per-bank status words. Software clears those bits by writing ones. Per-bank enable words mask the status, and one registered interrupt line reports whether any enabled status bit is set.

Top module: `gpio_pad_community`

## Requirements
- R1: A read of address 0x00C returns the pad array offset (parameter, default 0x200). Pad N's first word is at that offset + N x stride (stride 8 or 16 bytes, default 16), and its second word is 4 bytes above the first.
- R2: Word-0 bit 0 is the drive value of the pad. It appears on the pad's output bit one cycle after the write and reads back.
- R3: Word-0 bit 1 reads the raw pad input after two synchronising flops, so it is visible from the second clock edge after the input changes. Writes to this bit have no effect.
- R4: Word-0 bits 31:30 (reset field), 26:25 (event mode) and 23 (invert) read back as written, and all other word-0 bits except 1:0 read zero. Word 1 reads back all 32 bits as written.
- R5: In level mode (bits 26:25 = 00), the status bit is set on every cycle in which the inverted input is high, so it sets again right after a clear while the level holds.
- R6: In edge mode (bits 26:25 = 01), only a 0-to-1 transition of the inverted input sets the status bit.
- R7: In both-edge mode (bits 26:25 = 11), either transition sets the status bit. Mode 10 never sets it.
- R8: With bit 23 set, the synchronised input is inverted before event detection. The raw value in bit 1 is not inverted.
- R9: Status for bank b is at 0x100 + 4b, and bit i corresponds to pad b x 24 + i (24 pads per bank by default). Writing 1 clears a bit and writing 0 leaves it unchanged. An event in the same cycle wins over the clear.
- R10: Enable for bank b is at 0x120 + 4b and reads back as written. Bits with no pad behind them read zero.
- R11: The interrupt output is a register holding the OR over all banks of status AND enable. It rises one cycle after an enabled status bit sets and falls one cycle after the last one clears. Status bits that are not enabled do not raise it.
- R12: After synchronous reset, all configuration, status and enable bits are zero, the pad outputs are zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | NUM_PADS | Asynchronous pad input levels |
| pad_out | output | NUM_PADS | Drive values for the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
Faults in the input path show up at the ports with predictable latency. A wrong synchroniser depth moves the cycle in which bit 1 of a pad record changes. A wrong previous-sample register makes an edge-mode pad report a falling edge, or report the same edge twice after a clear. Faults in the status or enable logic show in the interrupt line: it rises a cycle early or late, stays high after the last clear, or rises for a masked bit. A stale status bit reads back at its bank address on the very next read.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    typedef enum logic [1:0] {
        EVM_LEVEL = 2'b00,
        EVM_RISE  = 2'b01,
        EVM_NONE  = 2'b10,
        EVM_BOTH  = 2'b11
    } evt_mode_e;

    typedef struct packed {
        logic [1:0] rst_cfg;
        evt_mode_e  mode;
        logic       inv;
        logic       tx;
    } pad_cfg_t;

    function automatic pad_cfg_t dw0_unpack(input logic [31:0] w);
        pad_cfg_t c;
        c.rst_cfg = w[31:30];
        c.mode    = evt_mode_e'(w[26:25]);
        c.inv     = w[23];
        c.tx      = w[0];
        return c;
    endfunction

    function automatic logic [31:0] dw0_pack(input pad_cfg_t c, input logic rx);
        logic [31:0] w;
        w        = '0;
        w[31:30] = c.rst_cfg;
        w[26:25] = c.mode;
        w[23]    = c.inv;
        w[1]     = rx;
        w[0]     = c.tx;
        return w;
    endfunction

    function automatic logic evt_fire(input evt_mode_e m, input logic cur, input logic prev);
        case (m)
            EVM_LEVEL: return cur;
            EVM_RISE:  return cur & ~prev;
            EVM_BOTH:  return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pad_event.sv
module gpio_pad_event
    import gpio_pad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pad_raw,
    input  logic      inv,
    input  evt_mode_e mode,
    output logic      rx_sync,
    output logic      evt
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       cur;

    assign rx_sync = sync_q[1];
    assign cur     = sync_q[1] ^ inv;
    assign evt     = evt_fire(mode, cur, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pad_raw};
            prev_q <= cur;
        end
    end

    // R6: a rising-edge event cannot repeat in the following cycle
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == EVM_RISE && evt) |=> !(mode == EVM_RISE && evt));

    // R7: mode 10 never produces an event
    p_none_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == EVM_NONE) |-> !evt);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt,
    input  logic             sts_we,
    input  logic             en_we,
    input  logic [31:0]      wdata,
    output logic [31:0]      sts_rd,
    output logic [31:0]      en_rd,
    output logic             pending
);
    logic [WIDTH-1:0] sts_q;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] clr;

    assign clr     = sts_we ? wdata[WIDTH-1:0] : '0;
    assign sts_rd  = 32'(sts_q);
    assign en_rd   = 32'(en_q);
    assign pending = |(sts_q & en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~clr) | evt;
            if (en_we) en_q <= wdata[WIDTH-1:0];
        end
    end

    // R9: bits written with 1 and not hit by an event are clear next cycle
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        sts_we |=> ((sts_q & $past(wdata[WIDTH-1:0] & ~evt)) == '0));

    // R5: every event is latched into status
    p_evt_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/gpio_pad_community.sv
module gpio_pad_community
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS      = 40,
    parameter int PADS_PER_BANK = 24,
    parameter int PAD_STRIDE    = 16,
    parameter int PADBAR        = 'h200,
    parameter int STS_BASE      = 'h100,
    parameter int EN_BASE       = 'h120,
    parameter int ADDR_W        = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PADS + PADS_PER_BANK - 1) / PADS_PER_BANK;
    localparam int STRIDE_SH = $clog2(PAD_STRIDE);
    localparam int DW_W      = STRIDE_SH - 2;
    localparam logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'('h00C);
    localparam logic [ADDR_W-1:0] PAD_LO   = ADDR_W'(PADBAR);
    localparam logic [ADDR_W-1:0] PAD_HI   = ADDR_W'(PADBAR + NUM_PADS * PAD_STRIDE);

    logic              pad_hit;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] pad_idx;
    logic [DW_W-1:0]   dw_sel;

    assign pad_hit = (reg_addr >= PAD_LO) && (reg_addr < PAD_HI);
    assign rel     = reg_addr - PAD_LO;
    assign pad_idx = rel >> STRIDE_SH;
    assign dw_sel  = rel[STRIDE_SH-1:2];

    logic [NUM_PADS-1:0] pad_sel_v;
    logic [NUM_PADS-1:0] evt_all;
    logic [31:0]         dw0_rd [NUM_PADS];
    logic [31:0]         dw1_rd [NUM_PADS];
    logic [31:0]         sts_rd [NUM_BANKS];
    logic [31:0]         en_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_cfg_t    cfg_q;
        logic [31:0] aux_q;
        logic        rx;
        logic        we0;
        logic        we1;

        assign pad_sel_v[p] = pad_hit && (pad_idx == ADDR_W'(p));
        assign we0 = reg_wr && pad_sel_v[p] && (dw_sel == DW_W'(0));
        assign we1 = reg_wr && pad_sel_v[p] && (dw_sel == DW_W'(1));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
                aux_q <= '0;
            end else begin
                if (we0) cfg_q <= dw0_unpack(reg_wdata);
                if (we1) aux_q <= reg_wdata;
            end
        end

        gpio_pad_event u_evt (
            .clk     (clk),
            .rst     (rst),
            .pad_raw (pad_in[p]),
            .inv     (cfg_q.inv),
            .mode    (cfg_q.mode),
            .rx_sync (rx),
            .evt     (evt_all[p])
        );

        assign pad_out[p] = cfg_q.tx;
        assign dw0_rd[p]  = dw0_pack(cfg_q, rx);
        assign dw1_rd[p]  = aux_q;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LEFT = NUM_PADS - b * PADS_PER_BANK;
        localparam int BW   = (LEFT < PADS_PER_BANK) ? LEFT : PADS_PER_BANK;
        logic sts_we;
        logic en_we;

        assign sts_we = reg_wr && (reg_addr == ADDR_W'(STS_BASE + 4 * b));
        assign en_we  = reg_wr && (reg_addr == ADDR_W'(EN_BASE + 4 * b));

        gpio_irq_bank #(.WIDTH(BW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt_all[b*PADS_PER_BANK +: BW]),
            .sts_we  (sts_we),
            .en_we   (en_we),
            .wdata   (reg_wdata),
            .sts_rd  (sts_rd[b]),
            .en_rd   (en_rd[b]),
            .pending (pend[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == PTR_ADDR) reg_rdata = 32'(PADBAR);
        for (int p = 0; p < NUM_PADS; p++) begin
            if (pad_sel_v[p]) begin
                if (dw_sel == DW_W'(0))      reg_rdata = dw0_rd[p];
                else if (dw_sel == DW_W'(1)) reg_rdata = dw1_rd[p];
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(STS_BASE + 4 * b)) reg_rdata = sts_rd[b];
            if (reg_addr == ADDR_W'(EN_BASE + 4 * b))  reg_rdata = en_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |pend;
    end

    // R11: an enabled pending bit raises the interrupt one cycle later
    p_irq_rise_r11: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq);

    // R11: with nothing enabled and pending, the interrupt drops one cycle later
    p_irq_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq);

endmodule

// File: tb/gpio_pad_community_test.sv
module gpio_pad_community_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 40;
    localparam int STR = 16;
    localparam int PB  = 'h200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic          irq;

    gpio_pad_community uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          q_kind [$];
    logic [63:0] q_exp  [$];
    string       q_tag  [$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [11:0] padr(input int p, input int dw);
        return 12'(PB + STR * p + 4 * dw);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        reg_addr = a;
        q_kind.push_back(0); q_exp.push_back(64'(e)); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        q_kind.push_back(1); q_exp.push_back(64'(e)); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic chk_out(input logic [NP-1:0] e, input string tag);
        q_kind.push_back(2); q_exp.push_back(64'(e)); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                int          k;
                logic [63:0] e;
                logic [63:0] act;
                string       t;
                k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
                if (k == 0)      act = 64'(reg_rdata);
                else if (k == 1) act = 64'(irq);
                else             act = 64'(pad_out);
                n_chk++;
                if (act !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R12 reset state, R1 pointer
        rd(12'h00C, 32'h200, "R1 pad array pointer");
        rd(padr(0, 0), 32'h0, "R12 cfg reset");
        rd(12'h100, 32'h0, "R12 status reset");
        rd(12'h120, 32'h0, "R12 enable reset");
        chk_irq(1'b0, "R12 irq low");
        chk_out('0, "R12 pad_out low");

        // R1/R4 word placement and readback
        wr(padr(39, 1), 32'hFFFF_FFFF);
        rd(padr(39, 1), 32'hFFFF_FFFF, "R4 word1 readback last pad");
        rd(padr(39, 0), 32'h0, "R1 word0 separate from word1");
        wr(padr(38, 0), 32'hFD7F_FFFE);
        rd(padr(38, 0), 32'hC400_0000, "R4 reserved bits zero");
        wr(padr(3, 0), 32'hC000_0001);
        rd(padr(3, 0), 32'hC000_0001, "R4 reset field readback");
        chk_out(NP'(1) << 3, "R2 pad_out follows tx");

        // R3 sync latency and read-only rx
        pad_in[5] = 1'b1;
        rd(padr(5, 0), 32'h0, "R3 before first edge");
        rd(padr(5, 0), 32'h0, "R3 after one edge");
        rd(padr(5, 0), 32'h2, "R3 after two edges");
        wr(padr(6, 0), 32'h2);
        rd(padr(6, 0), 32'h0, "R3 rx not writable");

        // R5 level mode, R9 W1C
        rd(12'h100, 32'h20, "R5 level sets status");
        pad_in[5] = 1'b0;
        step(4);
        wr(12'h100, 32'h0);
        rd(12'h100, 32'h20, "R9 writing zero keeps bit");
        wr(12'h100, 32'h20);
        rd(12'h100, 32'h0, "R9 write one clears");
        pad_in[7] = 1'b1;
        step(4);
        wr(12'h100, 32'h80);
        rd(12'h100, 32'h80, "R5 reasserts while level held");
        pad_in[7] = 1'b0;
        step(4);
        wr(12'h100, 32'h80);
        rd(12'h100, 32'h0, "R5 clears once level gone");

        // R6 rising edge, pad 30 = bank1 bit6
        wr(padr(30, 0), 32'h0200_0000);
        step(2);
        rd(12'h104, 32'h0, "R6 no event while low");
        pad_in[30] = 1'b1;
        step(4);
        rd(12'h104, 32'h40, "R6 rise sets status");
        wr(12'h104, 32'h40);
        step(2);
        rd(12'h104, 32'h0, "R6 held high no reassert");
        pad_in[30] = 1'b0;
        step(4);
        rd(12'h104, 32'h0, "R6 falling edge ignored");

        // R7 both edges, pad 31 = bank1 bit7; pad 32 mode 10
        wr(padr(31, 0), 32'h0600_0000);
        pad_in[31] = 1'b1;
        step(4);
        rd(12'h104, 32'h80, "R7 rise in both mode");
        wr(12'h104, 32'h80);
        pad_in[31] = 1'b0;
        step(4);
        rd(12'h104, 32'h80, "R7 fall in both mode");
        wr(12'h104, 32'h80);
        rd(12'h104, 32'h0, "R7 cleared");
        wr(padr(32, 0), 32'h0400_0000);
        pad_in[32] = 1'b1;
        step(4);
        pad_in[32] = 1'b0;
        step(4);
        rd(12'h104, 32'h0, "R7 mode 10 never fires");

        // R8 inversion
        wr(padr(10, 0), 32'h0080_0000);
        step(3);
        rd(12'h100, 32'h400, "R8 inverted low input is active");
        pad_in[10] = 1'b1;
        step(4);
        wr(12'h100, 32'h400);
        rd(12'h100, 32'h0, "R8 inverted high input quiet");
        rd(padr(10, 0), 32'h0080_0002, "R8 rx bit not inverted");
        wr(padr(11, 0), 32'h0280_0000);
        step(3);
        wr(12'h100, 32'h800);
        rd(12'h100, 32'h0, "R8 cleared setup event");
        pad_in[11] = 1'b1;
        step(4);
        rd(12'h100, 32'h0, "R8 input rise is inverted fall");
        pad_in[11] = 1'b0;
        step(4);
        rd(12'h100, 32'h800, "R8 input fall is inverted rise");
        wr(12'h100, 32'h800);

        // R10 enables
        wr(12'h124, 32'hFFFF_FFFF);
        rd(12'h124, 32'h0000_FFFF, "R10 partial bank width");
        wr(12'h120, 32'hFFFF_FFFF);
        rd(12'h120, 32'h00FF_FFFF, "R10 full bank width");
        chk_irq(1'b0, "R10 no status no irq");
        wr(12'h124, 32'h0);
        wr(12'h120, 32'h0010_0000);

        // R11 interrupt timing
        pad_in[20] = 1'b1;
        step(3);
        chk_irq(1'b0, "R11 irq not yet");
        chk_irq(1'b1, "R11 irq one cycle after status");
        rd(12'h100, 32'h0010_0000, "R11 status for pad 20");
        pad_in[20] = 1'b0;
        step(4);
        wr(12'h100, 32'h0010_0000);
        chk_irq(1'b1, "R11 irq lags clear");
        chk_irq(1'b0, "R11 irq drops");
        pad_in[21] = 1'b1;
        step(5);
        chk_irq(1'b0, "R11 masked status ignored");
        rd(12'h100, 32'h0020_0000, "R11 masked status present");

        step(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule